// File: doc/BRIEF.md
# SPI Master Serial Engine

This block is the bit-level engine of an SPI master. It accepts one word at a time from a transmit stream, shifts it out on MOSI most significant bit first while capturing MISO, and hands each completed received word to a receive stream. The serial clock comes from the system clock through a 9-bit divisor, so one SCK period is 2 x (divisor + 1) system clocks.

Clock polarity, the edge on which data changes, the MISO sample point and the word length (8, 16 or 32 bits) are static control inputs, sampled when a word starts. An optional hardware chip-select is driven low whenever the transmit stream has data waiting or a word is being shifted. An enable input gates the whole engine.

Both data interfaces use valid/ready. A transmit word is taken only when `tx_valid` and `tx_ready` are high on the same clock edge. `tx_ready` does not depend on `tx_valid`. A received word stays on `rx_data` with `rx_valid` high until `rx_ready` is seen. No new word starts while a received word is still held, so receive back-pressure stalls the serial line between words and never drops data.

Top module: `spi_shift_engine`

## Requirements
- R1: One SCK half-period lasts `baud_div`+1 system clocks. A word of N bits keeps `busy` high for exactly 2·N·(`baud_div`+1) clocks.
- R2: `word_sel` picks the word length: 0 gives 8 bits, 1 gives 16 bits, 2 gives 32 bits. The word is taken from the low bits of `tx_data` and returned in the low bits of `rx_data`, with the upper bits zero. The value 3 is reserved: no word is accepted and `tx_ready` stays low.
- R3: MOSI carries the word most significant bit first. Bit k (counting from the MSB, starting at 0) is driven for SCK half-periods 2k and 2k+1 of the word.
- R4: With `busy` low, SCK rests at `cpol` (high when `cpol`=1).
- R5: With `edge_sel`=1, SCK stays idle for half-period 0 and data changes on the active-to-idle edge. With `edge_sel`=0, SCK goes active at the start of the word and data changes on the idle-to-active edge. In both cases SCK is active in half-period h exactly when (h odd) XOR (`edge_sel`=0).
- R6: With `late_smp`=0, MISO is sampled at the end of each even half-period, which is the middle of the bit. With `late_smp`=1, it is sampled at the end of each odd half-period, which is the end of the bit. The first sampled bit becomes the MSB of the received word.
- R7: A received word is offered only after its last bit has been sampled. It is held unchanged until `rx_ready` is high. While it is held, no new word starts.
- R8: `tx_ready` is high only when the engine is enabled, not busy, the word size is valid, and the receive slot is free or being emptied in the same cycle. With `tx_valid` low the engine stays idle.
- R9: With `hw_cs_en`=1 and the engine enabled, `cs_n` is low whenever `tx_valid` or `busy` is high, and high otherwise. With `hw_cs_en`=0, `cs_n` stays high.
- R10: Clearing `enable` ends any word in progress on the next clock edge. SCK returns to its idle level and no received word is delivered.
- R11: `busy` rises on the clock edge that accepts a word and falls on the edge of the last half-period boundary. That is the same edge on which `rx_valid` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Engine enable; low aborts and idles |
| cpol | input | 1 | SCK idle level |
| edge_sel | input | 1 | 1: data changes on active-to-idle edge; 0: on idle-to-active edge |
| late_smp | input | 1 | 1: sample MISO at end of bit; 0: at middle |
| word_sel | input | 2 | Word length code (0=8, 1=16, 2=32, 3 reserved) |
| baud_div | input | 9 | Half-period divisor |
| hw_cs_en | input | 1 | Enable hardware chip-select |
| tx_valid | input | 1 | Transmit word available |
| tx_data | input | 32 | Transmit word |
| tx_ready | output | 1 | Engine takes the word this cycle |
| rx_valid | output | 1 | Received word available |
| rx_data | output | 32 | Received word |
| rx_ready | input | 1 | Consumer takes the received word |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Hardware chip-select, active low |
| busy | output | 1 | Word in progress |

## Verification
The bench sweeps every word length, all eight combinations of polarity, edge and sample point, and several divisors. It drives MISO with a different bit in every half-period. A design that samples on the wrong edge therefore picks up the neighbouring half-period's bit and returns a wrong word, and a divisor that is off by one shows up as a wrong busy length or a misplaced SCK edge. Further targeted runs cover four cases:
- Receive back-pressure. A design that started the next word anyway would overwrite the held word or raise `busy`.
- The reserved size code. A broken design would accept the word.
- An enable drop in the middle of a word. A broken design would keep clocking or deliver a partial word.
- The chip-select staying low across a stall. A broken design would release it while data is still waiting.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  typedef enum logic [1:0] {
    WS_8   = 2'd0,
    WS_16  = 2'd1,
    WS_32  = 2'd2,
    WS_RSV = 2'd3
  } wsize_e;

  // number of bits in a word for a size code (8 << code)
  function automatic int unsigned bits_of(wsize_e s);
    return 32'd8 << s;
  endfunction

endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  // R1: each half-period restarts the count from zero
  a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W = 32,
  parameter int PH_W   = $clog2(2 * DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start,
  input  logic              tick,
  input  logic [DATA_W-1:0] load_data,
  input  logic [PH_W-1:0]   nbits,
  input  logic              late,
  input  logic              miso,
  output logic              busy,
  output logic              ph_odd,
  output logic              mosi,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);

  localparam logic [PH_W-1:0] FULL_W = PH_W'(DATA_W);

  logic [DATA_W-1:0] tx_sh, rx_sh, rx_nxt;
  logic [PH_W-1:0]   ph, last_ph, shamt;
  logic              at_last, sample, shift_out;

  assign ph_odd    = ph[0];
  assign at_last   = (ph == last_ph);
  assign sample    = busy && tick && (ph[0] == late);
  assign shift_out = busy && tick && ph[0] && !at_last;
  assign rx_nxt    = sample ? {rx_sh[DATA_W-2:0], miso} : rx_sh;
  assign rx_word   = rx_nxt;
  assign done      = enable && busy && tick && at_last;
  assign mosi      = tx_sh[DATA_W-1];
  assign shamt     = FULL_W - nbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      ph      <= '0;
      last_ph <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
    end else if (!enable) begin
      busy <= 1'b0;
      ph   <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      ph      <= '0;
      last_ph <= (nbits << 1) - 1'b1;
      tx_sh   <= load_data << shamt;
      rx_sh   <= '0;
    end else if (busy && tick) begin
      rx_sh <= rx_nxt;
      if (shift_out) tx_sh <= tx_sh << 1;
      if (at_last) busy <= 1'b0;
      else         ph   <= ph + 1'b1;
    end
  end

  // R3: the phase never runs past the last half-period of the word
  a_r3_ph_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ph <= last_ph));
  // R11: the word-complete edge ends busy
  a_r11_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DATA_W = 32,
  parameter int DIV_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cpol,
  input  logic              edge_sel,
  input  logic              late_smp,
  input  logic [1:0]        word_sel,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              hw_cs_en,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_ready,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              cs_n,
  output logic              busy
);
  import spi_eng_pkg::*;

  localparam int PH_W = $clog2(2 * DATA_W);

  wsize_e            ws;
  logic [PH_W-1:0]   nbits;
  logic              tick, ph_odd, done, start, rx_room;
  logic [DATA_W-1:0] rx_word;

  assign ws       = wsize_e'(word_sel);
  assign nbits    = PH_W'(bits_of(ws));
  assign rx_room  = !rx_valid || rx_ready;
  assign tx_ready = enable && !busy && rx_room && (ws != WS_RSV);
  assign start    = tx_valid && tx_ready;

  spi_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy && enable),
    .div  (baud_div),
    .tick (tick)
  );

  spi_shifter #(.DATA_W(DATA_W), .PH_W(PH_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .start    (start),
    .tick     (tick),
    .load_data(tx_data),
    .nbits    (nbits),
    .late     (late_smp),
    .miso     (miso),
    .busy     (busy),
    .ph_odd   (ph_odd),
    .mosi     (mosi),
    .done     (done),
    .rx_word  (rx_word)
  );

  // active in half-period h when (h odd) xor (data changes on leading edge)
  assign sck  = cpol ^ (busy & (ph_odd ^ ~edge_sel));
  assign cs_n = !(hw_cs_en && enable && (tx_valid || busy));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (done) begin
      rx_valid <= 1'b1;
      rx_data  <= rx_word;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  // R7: a held received word stays put
  a_r7_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  // R7: no word in flight while the receive slot is occupied
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rx_valid);
  // R8: no accept while shifting
  a_r8_idle_accept: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !busy);
  // R10: disabling ends a word on the next edge
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy);
  // R9: chip-select unused when hardware select is off
  a_r9_cs_off: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_cs_en |-> cs_n);
  // R2: reserved size code never accepts
  a_r2_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (word_sel == 2'd3) |-> !tx_ready);

endmodule

// File: tb/test_spi_shift_engine.sv
module test_spi_shift_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        enable = 1'b0, cpol = 1'b0, edge_sel = 1'b1, late_smp = 1'b0;
  logic [1:0]  word_sel = 2'd0;
  logic [8:0]  baud_div = 9'd0;
  logic        hw_cs_en = 1'b0, tx_valid = 1'b0, rx_ready = 1'b1, miso = 1'b0;
  logic [31:0] tx_data = '0;
  logic        tx_ready, rx_valid, sck, mosi, cs_n, busy;
  logic [31:0] rx_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_shift_engine i_spi_shift_engine (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cpol(cpol), .edge_sel(edge_sel),
    .late_smp(late_smp), .word_sel(word_sel), .baud_div(baud_div), .hw_cs_en(hw_cs_en),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .miso(miso), .sck(sck), .mosi(mosi),
    .cs_n(cs_n), .busy(busy)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // bench view of the current word
  logic [31:0] cur_data = '0;
  logic [63:0] cur_pat  = '0;
  int          bcnt = 0, last_len = 0;
  int          mosi_err = 0, sck_err = 0, idle_sck_err = 0, cs_err = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nb(input logic [1:0] w);
    return 8 << w;
  endfunction

  function automatic logic [31:0] exp_rx(input logic [63:0] p, input int n, input bit lt);
    logic [31:0] r = '0;
    for (int k = 0; k < n; k++) r[n-1-k] = p[2*k + int'(lt)];
    return r;
  endfunction

  // monitor: drives MISO per half-period and checks waveforms
  always @(negedge clk) begin
    #2;
    if (busy) begin
      int h, idx;
      logic exp_sck;
      h   = bcnt / (int'(baud_div) + 1);
      idx = nb(word_sel) - 1 - h / 2;
      miso = cur_pat[h];
      if (idx >= 0 && mosi !== cur_data[idx]) mosi_err++;
      exp_sck = cpol ^ (h[0] ^ ~edge_sel);
      if (sck !== exp_sck) sck_err++;
      bcnt++;
    end else begin
      if (bcnt != 0) last_len = bcnt;
      bcnt = 0;
      if (sck !== cpol) idle_sck_err++;
    end
    if (cs_n !== !(hw_cs_en && enable && (tx_valid || busy))) cs_err++;
  end

  task automatic send(input logic [31:0] d);
    tx_data = d; tx_valid = 1'b1;
    #1;
    while (!tx_ready) begin @(negedge clk); #1; end
    @(negedge clk);
  endtask

  task automatic wait_rx();
    int g = 0;
    while (!rx_valid && g < 5000) begin @(negedge clk); g++; end
  endtask

  task automatic run_word(input logic [1:0] ws, input bit cp, input bit ed, input bit lt,
                          input bit hw, input logic [8:0] dv, input logic [31:0] d,
                          input logic [63:0] p);
    int n;
    logic [31:0] got, expd;
    @(negedge clk);
    word_sel = ws; cpol = cp; edge_sel = ed; late_smp = lt; hw_cs_en = hw; baud_div = dv;
    rx_ready = 1'b1; cur_pat = p; mosi_err = 0; sck_err = 0;
    n = nb(ws);
    cur_data = d & ((n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1));
    send(d);
    tx_valid = 1'b0;
    wait_rx();
    got = rx_data;
    expd = exp_rx(p, n, lt);
    @(negedge clk);
    @(negedge clk);
    check(got == expd, "R2/R6 rx word", 64'(got), 64'(expd));
    check(mosi_err == 0, "R3 mosi order", 64'(mosi_err), 0);
    check(sck_err == 0, "R5 sck waveform", 64'(sck_err), 0);
    check(last_len == 2 * n * (int'(dv) + 1), "R1 R11 busy length",
          64'(last_len), 64'(2 * n * (int'(dv) + 1)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    check(busy == 0 && rx_valid == 0 && cs_n == 1 && tx_ready == 0 && sck == 0,
          "R4 R8 reset state", {busy, rx_valid, cs_n, tx_ready, sck}, 5'b00100);
    rst_n = 1'b1; enable = 1'b1;
    @(negedge clk);
    // R8: empty TX stays idle
    repeat (5) @(negedge clk);
    check(busy == 0 && rx_valid == 0, "R8 idle on empty tx", {busy, rx_valid}, 0);

    // full sweep
    for (int ws = 0; ws < 3; ws++)
      for (int m = 0; m < 8; m++)
        for (int di = 0; di < 3; di++) begin
          logic [31:0] d;
          logic [8:0] dv;
          dv = (di == 0) ? 9'd0 : (di == 1) ? 9'd1 : 9'd3;
          d  = 32'h9E37_79B9 * (ws * 24 + m * 3 + di + 1);
          run_word(ws[1:0], m[0], m[1], m[2], (ws + m) % 2 == 1, dv, d,
                   {d ^ 32'h5A5A_C3C3, ~d});
        end

    // R2: reserved size code
    @(negedge clk);
    word_sel = 2'd3; tx_data = 32'h1234_5678; tx_valid = 1'b1;
    repeat (8) @(negedge clk);
    check(busy == 0 && tx_ready == 0, "R2 reserved size", {busy, tx_ready}, 0);
    tx_valid = 1'b0;

    // R7/R9: receive back-pressure with chip-select held
    begin
      logic [31:0] ea, eb;
      @(negedge clk);
      word_sel = 2'd0; cpol = 0; edge_sel = 1; late_smp = 0; hw_cs_en = 1; baud_div = 9'd1;
      cur_pat = 64'hF0F0_3C3C_9696_A5A5; rx_ready = 1'b0;
      cur_data = 32'h0000_00C5;
      ea = exp_rx(cur_pat, 8, 0);
      eb = ea;
      send(32'h0000_00C5);
      tx_data = 32'h0000_003A;
      wait_rx();
      check(rx_data == ea, "R7 first word", 64'(rx_data), 64'(ea));
      repeat (10) @(negedge clk);
      check(busy == 0 && tx_ready == 0 && rx_valid == 1, "R7 stall while held",
            {busy, tx_ready, rx_valid}, 3'b001);
      check(rx_data == ea, "R7 held word stable", 64'(rx_data), 64'(ea));
      check(cs_n == 0, "R9 cs low while tx pending", 64'(cs_n), 0);
      cur_data = 32'h0000_003A; mosi_err = 0;
      rx_ready = 1'b1;
      #1;
      check(tx_ready == 1, "R8 ready when slot empties", 64'(tx_ready), 1);
      @(negedge clk);
      tx_valid = 1'b0;
      check(rx_valid == 0 && busy == 1, "R7 pop and restart", {rx_valid, busy}, 2'b01);
      wait_rx();
      check(rx_data == eb, "R7 second word", 64'(rx_data), 64'(eb));
      check(mosi_err == 0, "R3 second word mosi", 64'(mosi_err), 0);
      @(negedge clk);
      check(cs_n == 1, "R9 cs release after drain", 64'(cs_n), 1);
    end

    // R10: abort mid-word
    @(negedge clk);
    word_sel = 2'd2; baud_div = 9'd3; cpol = 1; edge_sel = 0; hw_cs_en = 0;
    cur_data = 32'hDEAD_BEEF;
    send(32'hDEAD_BEEF);
    tx_valid = 1'b0;
    repeat (20) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(busy == 0 && sck == 1, "R10 abort idles", {busy, sck}, 2'b01);
    repeat (5) @(negedge clk);
    check(rx_valid == 0, "R10 no partial word", 64'(rx_valid), 0);
    enable = 1'b1;
    @(negedge clk);

    check(idle_sck_err == 0, "R4 idle level", 64'(idle_sck_err), 0);
    check(cs_err == 0, "R9 chip-select", 64'(cs_err), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule